// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A caller presents a translation request made of the virtual address, a read/write flag and a user/kernel flag. The walker takes the root table address from a base input and reads one 4-byte entry from the root table. When that entry allows the walk to go on, it reads one 4-byte entry from the second-level table that the root entry names. Each of the two reads waits for its memory response before anything else happens.

The virtual address splits into three fields. The upper 10 bits index the root table, the next 10 bits index the second-level table, and the low 12 bits are the offset within a 4 KB page. Every entry uses the same layout: bit 0 is valid, bit 1 permits writes, bit 2 permits user-mode access, and bits 31:12 hold a page-frame number. That number is the next table's base at the root level and the physical page at the second level. The walker checks each entry as it arrives. The walk ends with a one-cycle completion pulse that carries either a physical address, a page fault or a protection fault. The block leaves the handling of faults, the caching of translations and any update of entries to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the cycles after it, `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: The first read of a walk goes to `ptbr + vaddr[31:22]*4`. Each read is a one-cycle pulse on `mem_req_valid`.
- R3: After a usable root entry E1, the second read goes to `{E1[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: At most one read is outstanding. The next read is issued only after the response to the previous one, whatever the response latency.
- R5: When both entries are usable, `done` pulses for exactly one cycle with `paddr = {E2[31:12], vaddr[11:0]}` and both fault flags at 0. The pulse comes one cycle after the second response.
- R6: A root entry with bit 0 (valid) clear ends the walk with `page_fault`=1 and `paddr`=0, and no second read is issued.
- R7: A second-level entry with bit 0 clear gives `page_fault`=1 and `paddr`=0.
- R8: A write request whose entry at either level has bit 1 (writable) clear gives `prot_fault`=1 and `paddr`=0. A fault at the root ends the walk after one read.
- R9: A user request (`req_user`=1) whose entry at either level has bit 2 (user) clear gives `prot_fault`=1. Kernel requests ignore bit 2.
- R10: An entry that is not valid reports a page fault even when its permission bits would also fail. The page fault takes priority over the protection fault.
- R11: A request is accepted only while `req_ready`=1. A `req_valid` raised during a walk is ignored: it causes no read and no extra result.
- R12: `page_fault` and `prot_fault` are never both 1 together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr | input | 32 | Byte address of the root table |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Entry contents |
| done | output | 1 | One-cycle result pulse |
| paddr | output | 32 | Physical address, 0 on a fault |
| page_fault | output | 1 | Entry not present |
| prot_fault | output | 1 | Access rights insufficient |

## Verification
The hardest case to reach is a new request that arrives while a read is still in flight. The walker must ignore it, then finish the first walk with the first address and stay idle afterwards. The bench's memory responder has an adjustable latency, so the response gap can be stretched to several cycles. The bench raises `req_valid` with another address during that gap and drops it before the walk ends. A prepared table also holds entries that fail at the root level, so that a missing second read can be observed, and entries that are invalid with every permission bit clear, so that the fault priority can be observed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry flag positions decoded by the checker stage
    localparam int PTE_V_BIT = 0;
    localparam int PTE_W_BIT = 1;
    localparam int PTE_U_BIT = 2;
    localparam int PTE_FLAGS = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        CHK_OK   = 2'd0,
        CHK_PAGE = 2'd1,
        CHK_PROT = 2'd2
    } chk_res_e;

endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [PTE_FLAGS-1:0] flags,
    input  logic                 is_write,
    input  logic                 is_user,
    output chk_res_e             res
);

    always_comb begin
        if (!flags[PTE_V_BIT]) begin
            // absence beats any rights problem
            res = CHK_PAGE;
        end else if ((is_write && !flags[PTE_W_BIT]) ||
                     (is_user  && !flags[PTE_U_BIT])) begin
            res = CHK_PROT;
        end else begin
            res = CHK_OK;
        end
    end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW        = 32,
    parameter int IDX_W     = 10,
    parameter int LEVELS    = 2,
    parameter int ENT_BYTES = 4,
    parameter int LVL_W     = 1
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [AW-1:0]           base,
    input  logic [LVL_W-1:0]        level,
    output logic [AW-1:0]           addr
);

    localparam int SH = $clog2(ENT_BYTES);

    logic [IDX_W-1:0] idx [LEVELS];
    logic [IDX_W-1:0] sel;

    // level 0 takes the most significant slice of the page number
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) sel = idx[i];
        end
        addr = base + (AW'(sel) << SH);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int LEVELS    = 2,
    parameter int PTE_W     = 32,
    parameter int ENT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [PA_W-1:0]  ptbr,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             page_fault,
    output logic             prot_fault
);

    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int PPN_W = PA_W - OFF_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_st_e           st;
        logic [LVL_W-1:0]   lvl;
        logic [VA_W-1:0]    va;
        logic               wr;
        logic               usr;
        logic [PA_W-1:0]    tbase;
        logic [PA_W-1:0]    pa;
        logic               pf;
        logic               xf;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    chk_res_e         chk;
    logic [PPN_W-1:0] rsp_ppn;
    logic [PA_W-1:0]  ent_addr;
    logic             unused_pte_bits;

    assign rsp_ppn         = PPN_W'(mem_rsp_data >> OFF_W);
    assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:PTE_FLAGS];

    ptw_perm_check u_perm (
        .flags    (mem_rsp_data[PTE_FLAGS-1:0]),
        .is_write (r_q.wr),
        .is_user  (r_q.usr),
        .res      (chk)
    );

    ptw_entry_addr #(
        .AW        (PA_W),
        .IDX_W     (IDX_W),
        .LEVELS    (LEVELS),
        .ENT_BYTES (ENT_BYTES),
        .LVL_W     (LVL_W)
    ) u_eaddr (
        .vpn   (r_q.va[OFF_W +: LEVELS*IDX_W]),
        .base  (r_q.tbase),
        .level (r_q.lvl),
        .addr  (ent_addr)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_vaddr;
                    r_d.wr    = req_write;
                    r_d.usr   = req_user;
                    r_d.tbase = ptbr;
                    r_d.lvl   = '0;
                    r_d.pa    = '0;
                    r_d.pf    = 1'b0;
                    r_d.xf    = 1'b0;
                    r_d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    case (chk)
                        CHK_PAGE: begin
                            r_d.pf = 1'b1;
                            r_d.pa = '0;
                            r_d.st = ST_RESP;
                        end
                        CHK_PROT: begin
                            r_d.xf = 1'b1;
                            r_d.pa = '0;
                            r_d.st = ST_RESP;
                        end
                        default: begin
                            if (r_q.lvl == LAST_LVL) begin
                                r_d.pa = {rsp_ppn, r_q.va[OFF_W-1:0]};
                                r_d.st = ST_RESP;
                            end else begin
                                r_d.tbase = {rsp_ppn, OFF_W'(0)};
                                r_d.lvl   = r_q.lvl + LVL_W'(1);
                                r_d.st    = ST_ISSUE;
                            end
                        end
                    endcase
                end
            end
            ST_RESP: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_ISSUE);
    assign mem_req_addr  = ent_addr;
    assign done          = (r_q.st == ST_RESP);
    assign paddr         = r_q.pa;
    assign page_fault    = r_q.pf;
    assign prot_fault    = r_q.xf;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             mem_req_valid,
    input logic             mem_rsp_valid,
    input logic             done,
    input logic [PA_W-1:0]  paddr,
    input logic             page_fault,
    input logic             prot_fault
);

    logic             pend_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            off_q  <= '0;
        end else begin
            if (mem_req_valid)      pend_q <= 1'b1;
            else if (mem_rsp_valid) pend_q <= 1'b0;
            if (req_valid && req_ready) off_q <= req_off;
        end
    end

    // R2
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !page_fault && !prot_fault) |-> (paddr[OFF_W-1:0] == off_q));

    // R7
    fault_noaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (page_fault || prot_fault)) |-> (paddr == '0));

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R12
    excl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(page_fault && prot_fault));

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .paddr         (paddr),
    .page_fault    (page_fault),
    .prot_fault    (prot_fault)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] ptbr = 32'h0001_0000;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] paddr;
    logic        page_fault;
    logic        prot_fault;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    ptw_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_user      (req_user),
        .ptbr          (ptbr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .paddr         (paddr),
        .page_fault    (page_fault),
        .prot_fault    (prot_fault)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- page table memory and responder ----------------
    logic [31:0] mem [logic [31:0]];
    int          lat_cfg = 0;
    int          lat_cnt = 0;
    bit          rsp_pend = 0;
    logic [31:0] rsp_addr = '0;
    int          rd_count = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
            rsp_pend      = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (rsp_pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(rsp_addr);
                    rsp_pend      = 0;
                end else begin
                    lat_cnt--;
                end
            end
            if (mem_req_valid) begin
                rsp_pend = 1;
                lat_cnt  = lat_cfg;
                rsp_addr = mem_req_addr;
                rd_count++;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0;   // 0 idle,1 read1,2 wait1,3 read2,4 wait2,5 result
    logic [31:0] m_va, m_tb, m_pa, m_pte;
    bit          m_w, m_u, m_pf, m_xf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_va = req_vaddr; m_w = req_write; m_u = req_user;
                    m_tb = ptbr; m_ph = 1;
                end
                1: m_ph = 2;
                3: m_ph = 4;
                2, 4: if (mem_rsp_valid) begin
                    m_pte = mem_rsp_data;
                    if (!m_pte[0]) begin
                        m_pf = 1; m_xf = 0; m_pa = 0; m_ph = 5;
                    end else if ((m_w && !m_pte[1]) || (m_u && !m_pte[2])) begin
                        m_pf = 0; m_xf = 1; m_pa = 0; m_ph = 5;
                    end else if (m_ph == 2) begin
                        m_tb = m_pte & 32'hFFFF_F000; m_ph = 3;
                    end else begin
                        m_pf = 0; m_xf = 0; m_pa = {m_pte[31:12], m_va[11:0]}; m_ph = 5;
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] ea;
            chk(req_ready == (m_ph == 0), "R11 req_ready per cycle", req_ready, (m_ph == 0));
            chk(mem_req_valid == (m_ph == 1 || m_ph == 3), "R4 read issue per cycle",
                mem_req_valid, (m_ph == 1 || m_ph == 3));
            if (m_ph == 1) begin
                ea = m_tb + {20'h0, m_va[31:22], 2'b00};
                chk(mem_req_addr == ea, "R2 root entry address", mem_req_addr, ea);
            end
            if (m_ph == 3) begin
                ea = m_tb + {20'h0, m_va[21:12], 2'b00};
                chk(mem_req_addr == ea, "R3 second entry address", mem_req_addr, ea);
            end
            chk(done == (m_ph == 5), "R5 done pulse per cycle", done, (m_ph == 5));
            if (m_ph == 5) begin
                chk(paddr == m_pa, "R5 model paddr", paddr, m_pa);
                chk(page_fault == m_pf, "R6 model page_fault", page_fault, m_pf);
                chk(prot_fault == m_xf, "R8 model prot_fault", prot_fault, m_xf);
                chk(!(page_fault && prot_fault), "R12 exclusive faults",
                    {page_fault, prot_fault}, 2'b00);
            end
        end
    end

    // ---------------- directed walks ----------------
    task automatic walk(input logic [31:0] va, input bit w, input bit u,
                        input bit epf, input bit exf, input logic [31:0] epa,
                        input int ereads, input string tag);
        int rc0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
        rc0 = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(paddr == epa, {tag, " paddr"}, paddr, epa);
        chk(page_fault == epf, {tag, " page_fault"}, page_fault, epf);
        chk(prot_fault == exf, {tag, " prot_fault"}, prot_fault, exf);
        chk(rd_count - rc0 == ereads, {tag, " read count"}, rd_count - rc0, ereads);
    endtask

    initial begin
        // root table at 0x10000
        mem[32'h0001_0000] = 32'h0007_0007;  // idx 0
        mem[32'h0001_0004] = 32'h0002_0007;  // idx 1
        mem[32'h0001_000C] = 32'h0003_0005;  // idx 3: no write
        mem[32'h0001_0010] = 32'h0004_0003;  // idx 4: kernel only
        mem[32'h0001_0014] = 32'h0005_0006;  // idx 5: invalid, W and U set
        mem[32'h0001_0FFC] = 32'h0006_0007;  // idx 1023
        // second-level tables
        mem[32'h0002_000C] = 32'h0055_5007;
        mem[32'h0002_0014] = 32'h0066_6005;  // no write
        mem[32'h0002_0018] = 32'h0077_7003;  // kernel only
        mem[32'h0002_001C] = 32'h00AB_C000;  // invalid, no rights
        mem[32'h0003_0004] = 32'h0088_8007;
        mem[32'h0004_0008] = 32'h0099_9007;
        mem[32'h0006_0FFC] = 32'hFFFF_F007;
        mem[32'h0007_0000] = 32'h0000_1007;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 no read in reset", mem_req_valid, 0);
        chk(done == 1'b0, "R1 no done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0,
            "R1 idle after reset", {req_ready, mem_req_valid, done}, 3'b100);

        // R5 success at several latencies
        walk(32'h0040_3ABC, 1, 1, 0, 0, 32'h0055_5ABC, 2, "R5 lat0");
        lat_cfg = 3;
        walk(32'h0040_3ABC, 1, 1, 0, 0, 32'h0055_5ABC, 2, "R4 R5 lat3");
        lat_cfg = 7;
        walk(32'h0040_3ABC, 0, 0, 0, 0, 32'h0055_5ABC, 2, "R4 lat7");
        lat_cfg = 1;
        // boundaries
        walk(32'hFFFF_FFFF, 0, 1, 0, 0, 32'hFFFF_FFFF, 2, "R2 R3 top index");
        walk(32'h0000_0000, 1, 0, 0, 0, 32'h0000_1000, 2, "R2 R3 zero address");
        // R6 root invalid
        walk(32'h0080_0123, 0, 0, 1, 0, 32'h0, 1, "R6 root absent");
        // R7 second-level invalid
        walk(32'h0040_4010, 0, 0, 1, 0, 32'h0, 2, "R7 leaf absent");
        // R8 write rights
        walk(32'h0040_5020, 1, 1, 0, 1, 32'h0, 2, "R8 leaf read-only write");
        walk(32'h0040_5020, 0, 1, 0, 0, 32'h0066_6020, 2, "R8 leaf read-only read");
        walk(32'h00C0_1004, 1, 0, 0, 1, 32'h0, 1, "R8 root read-only write");
        walk(32'h00C0_1004, 0, 0, 0, 0, 32'h0088_8004, 2, "R8 root read-only read");
        // R9 user rights
        walk(32'h0040_6FFF, 0, 1, 0, 1, 32'h0, 2, "R9 leaf kernel-only user");
        walk(32'h0040_6FFF, 1, 0, 0, 0, 32'h0077_7FFF, 2, "R9 leaf kernel bypass");
        walk(32'h0100_2008, 0, 1, 0, 1, 32'h0, 1, "R9 root kernel-only user");
        walk(32'h0100_2008, 0, 0, 0, 0, 32'h0099_9008, 2, "R9 root kernel bypass");
        // R10 priority
        walk(32'h0040_7000, 1, 1, 1, 0, 32'h0, 2, "R10 leaf invalid no rights");
        walk(32'h0140_0000, 1, 1, 1, 0, 32'h0, 1, "R10 root invalid");
        // R2 new base register value
        ptbr = 32'h0009_0000;
        walk(32'h0040_3ABC, 0, 0, 1, 0, 32'h0, 1, "R2 other base");
        ptbr = 32'h0001_0000;

        // R11 requests during a walk are ignored
        lat_cfg = 5;
        begin
            int rc0;
            @(negedge clk);
            req_valid = 1'b1; req_vaddr = 32'h0040_3ABC; req_write = 0; req_user = 0;
            rc0 = rd_count;
            @(negedge clk);
            req_vaddr = 32'h0000_0000;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            while (!done) @(negedge clk);
            chk(paddr == 32'h0055_5ABC, "R11 first walk kept", paddr, 32'h0055_5ABC);
            repeat (4) @(negedge clk);
            chk(rd_count - rc0 == 2, "R11 no extra reads", rd_count - rc0, 2);
            chk(req_ready == 1'b1 && done == 1'b0, "R11 idle afterwards",
                {req_ready, done}, 2'b10);
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule